// File: doc/BRIEF.md
# Channel packet formatter

The formatter sits between a channel arbiter and a downstream consumer. Once the arbiter has picked a channel, that channel's words are presented on a single input port, together with the channel number and the channel's packet-size code. The formatter takes in one whole packet into a local buffer. It then raises a request to the downstream side, carrying the channel number and the packet length in words. It waits for a grant, and then plays the packet out on back-to-back cycles, marking the first and last words.

The size code picks a power-of-two length: four words shifted left by the code's two low bits. The channel number and the code are taken once, together with the first word of a packet, so later changes on those inputs do not alter a packet that is already being gathered. While a packet waits for its grant or is being sent, the input side is closed and no word is taken.

Top module: `pkt_formatter`

## Requirements
- R1: After reset, `req`, `out_valid`, `out_start` and `out_end` are low and `in_ready` is high.
- R2: The packet length in words, shown on `pkt_len`, is 4 << `in_len_code[1:0]` (4, 8, 16 or 32). Bit 2 of the code has no effect.
- R3: `pkt_id` equals the `in_id` presented with the packet's first accepted word. Output words leave in the order they were accepted.
- R4: `req` is high from the cycle after the last word of a packet is accepted. It stays high, with `pkt_id` and `pkt_len` unchanged, until a grant is taken.
- R5: A grant is ignored in the first cycle that `req` is high, and also whenever `req` is low.
- R6: In the cycle after a grant is taken, `out_valid` rises and stays high for exactly `pkt_len` consecutive cycles, with `req` low. `out_start` is high only on the first of those words and `out_end` only on the last.
- R7: `in_id` and `in_len_code` are sampled only with a packet's first word. Changes on them while the rest of that packet is gathered do not affect its id, its length or the number of words taken.
- R8: `in_ready` is low from the cycle after the last input word is accepted until the last output word has been sent. It is high again in the following cycle, and words offered while it is low are not taken.
- R9: Input words may arrive with idle cycles between them. Only cycles with `in_valid` and `in_ready` both high count toward the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word from the selected channel is present |
| in_id | input | 2 | Number of the selected channel |
| in_len_code | input | 3 | Packet-size code of the selected channel |
| in_data | input | 32 | Word from the selected channel |
| in_ready | output | 1 | Formatter takes the offered word this cycle |
| grant | input | 1 | Downstream accepts the pending request |
| req | output | 1 | A full packet waits to be sent |
| pkt_id | output | 2 | Channel number of the pending or outgoing packet |
| pkt_len | output | 6 | Length in words of the pending or outgoing packet |
| out_valid | output | 1 | An output word is present |
| out_data | output | 32 | Output word |
| out_start | output | 1 | First word of the packet |
| out_end | output | 1 | Last word of the packet |

## Verification
The bench runs every length code, including codes with bit 2 set. A design that decoded three bits would send the wrong number of words, and `out_end` would fall on the wrong cycle. It pulses grant in the very first request cycle and before any request. A formatter that took such a grant would start sending early or send from an empty buffer. While the packet is gathered, the bench changes the channel number and size code, and it keeps offering junk words while the packet waits and while it is sent. A design that re-sampled those inputs or kept its input open would then show a wrong id, a wrong length or junk in the output words. Idle gaps on the input show whether a design counts cycles instead of accepted words.

// File: rtl/pkt_fmt_pkg.sv
package pkt_fmt_pkg;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_FILL = 2'd1,
    PF_ASK  = 2'd2,
    PF_SEND = 2'd3
  } pf_state_e;

  // packet words for a size code: base shifted by the two low code bits
  function automatic int unsigned words_for_code(input int unsigned base,
                                                 input logic [1:0] code);
    return base << code;
  endfunction

endpackage

// File: rtl/pkt_fmt_store.sv
module pkt_fmt_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pkt_fmt_ctrl.sv
module pkt_fmt_ctrl
  import pkt_fmt_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int CODE_W     = 3,
  parameter int BASE_WORDS = 4,
  localparam int MAX_WORDS = BASE_WORDS << 3,
  localparam int ADDR_W    = $clog2(MAX_WORDS),
  localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [CODE_W-1:0] in_len_code,
  output logic              in_ready,
  input  logic              grant,
  output logic              req,
  output logic [ID_W-1:0]   pkt_id,
  output logic [CNT_W-1:0]  pkt_len,
  output logic              out_valid,
  output logic              out_start,
  output logic              out_end,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);

  pf_state_e        state;
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] rd_cnt;
  logic [ID_W-1:0]  lat_id;
  logic [CNT_W-1:0] lat_len;
  logic             ask_aged;

  // named internal events
  logic             accept;
  logic             first_in;
  logic             last_in;
  logic             grant_taken;
  logic             last_out;
  logic [CNT_W-1:0] code_len;

  assign code_len    = CNT_W'(words_for_code(BASE_WORDS, in_len_code[1:0]));
  assign in_ready    = (state == PF_IDLE) || (state == PF_FILL);
  assign accept      = in_valid && in_ready;
  assign first_in    = accept && (state == PF_IDLE);
  assign last_in     = accept && (state == PF_FILL) && (wr_cnt + CNT_W'(1) == lat_len);
  assign grant_taken = (state == PF_ASK) && ask_aged && grant;
  assign last_out    = (state == PF_SEND) && (rd_cnt == lat_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PF_IDLE;
      wr_cnt   <= '0;
      rd_cnt   <= '0;
      lat_id   <= '0;
      lat_len  <= CNT_W'(BASE_WORDS);
      ask_aged <= 1'b0;
    end else begin
      unique case (state)
        PF_IDLE: begin
          if (first_in) begin
            lat_id  <= in_id;
            lat_len <= code_len;
            wr_cnt  <= CNT_W'(1);
            state   <= PF_FILL;
          end
        end
        PF_FILL: begin
          if (accept) begin
            wr_cnt <= wr_cnt + CNT_W'(1);
            if (last_in) begin
              state    <= PF_ASK;
              ask_aged <= 1'b0;
            end
          end
        end
        PF_ASK: begin
          ask_aged <= 1'b1;
          if (grant_taken) begin
            rd_cnt <= '0;
            state  <= PF_SEND;
          end
        end
        PF_SEND: begin
          rd_cnt <= rd_cnt + CNT_W'(1);
          if (last_out) state <= PF_IDLE;
        end
        default: state <= PF_IDLE;
      endcase
    end
  end

  assign req       = (state == PF_ASK);
  assign out_valid = (state == PF_SEND);
  assign out_start = out_valid && (rd_cnt == '0);
  assign out_end   = last_out;
  assign pkt_id    = lat_id;
  assign pkt_len   = lat_len;
  assign wr_en     = accept;
  assign wr_addr   = (state == PF_IDLE) ? '0 : wr_cnt[ADDR_W-1:0];
  assign rd_addr   = rd_cnt[ADDR_W-1:0];

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !grant |=> req && $stable(pkt_id) && $stable(pkt_len));

  // R5
  early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |=> req);

  // R2
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($countones(pkt_len) == 1) && (pkt_len >= CNT_W'(BASE_WORDS)));

  // R6
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_end |=> out_valid && !out_start);

  // R6
  grant_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_taken |=> out_valid && out_start);

  // R6
  req_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req, out_valid}));

  // R8
  input_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req || out_valid) |-> !in_ready);

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_end |=> in_ready && !out_valid);

endmodule

// File: rtl/pkt_formatter.sv
module pkt_formatter #(
  parameter int DATA_W     = 32,
  parameter int ID_W       = 2,
  parameter int CODE_W     = 3,
  parameter int BASE_WORDS = 4,
  localparam int MAX_WORDS = BASE_WORDS << 3,
  localparam int ADDR_W    = $clog2(MAX_WORDS),
  localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [CODE_W-1:0] in_len_code,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              grant,
  output logic              req,
  output logic [ID_W-1:0]   pkt_id,
  output logic [CNT_W-1:0]  pkt_len,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_end
);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  pkt_fmt_ctrl #(
    .ID_W       (ID_W),
    .CODE_W     (CODE_W),
    .BASE_WORDS (BASE_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_id       (in_id),
    .in_len_code (in_len_code),
    .in_ready    (in_ready),
    .grant       (grant),
    .req         (req),
    .pkt_id      (pkt_id),
    .pkt_len     (pkt_len),
    .out_valid   (out_valid),
    .out_start   (out_start),
    .out_end     (out_end),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr)
  );

  pkt_fmt_store #(
    .DATA_W (DATA_W),
    .DEPTH  (MAX_WORDS)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

endmodule

// File: tb/pkt_formatter_test.sv
module pkt_formatter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_id = '0;
  logic [2:0]  in_len_code = '0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        grant = 1'b0;
  logic        req;
  logic [1:0]  pkt_id;
  logic [5:0]  pkt_len;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_start;
  logic        out_end;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tagc = 0;

  always #10 clk = ~clk;

  pkt_formatter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
    .in_len_code(in_len_code), .in_data(in_data), .in_ready(in_ready),
    .grant(grant), .req(req), .pkt_id(pkt_id), .pkt_len(pkt_len),
    .out_valid(out_valid), .out_data(out_data), .out_start(out_start),
    .out_end(out_end)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !out_valid && !out_start && !out_end, "R1 outputs idle",
        {req, out_valid, out_start, out_end}, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);
  endtask

  // one packet: gather, request, grant, send, all checked here
  task automatic run_pkt(input int id, input int code, input int gap, input int hold,
                         input bit early, input bit perturb, input bit flood);
    int n;
    logic [31:0] exp_w [32];
    n = 4 << (code & 3);
    tagc++;
    for (int i = 0; i < n; i++) exp_w[i] = {8'(id), 8'(tagc), 16'(i)};
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0;
          in_data  = 32'hBAD0_0000 | 32'(g);
          @(negedge clk);
          chk(!req, "R9 no request during gap", req, 0);
        end
      end
      in_valid    = 1'b1;
      in_data     = exp_w[i];
      in_id       = (perturb && i > 0) ? 2'((id + 1) % 3) : 2'(id);
      in_len_code = (perturb && i > 0) ? 3'(code ^ 3) : 3'(code);
      if (i > 0) chk(in_ready, "R8 ready while gathering", in_ready, 1);
      @(negedge clk);
    end
    in_valid = flood;
    in_data  = 32'hDEAD_BEEF;
    chk(req, "R4 request after last word", req, 1);
    chk(pkt_len == 6'(n), "R2 length", pkt_len, n);
    chk(pkt_id == 2'(id), "R3 id", pkt_id, id);
    chk(!in_ready, "R8 input closed", in_ready, 0);
    if (perturb) chk(pkt_len == 6'(n) && pkt_id == 2'(id), "R7 sampled once",
                     {pkt_id, pkt_len}, {2'(id), 6'(n)});
    if (early) begin
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      chk(req && !out_valid, "R5 first-cycle grant ignored", {req, out_valid}, 2'b10);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(req && pkt_id == 2'(id) && pkt_len == 6'(n), "R4 request held",
          {req, pkt_id, pkt_len}, {1'b1, 2'(id), 6'(n)});
    end
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(out_valid && !req, "R6 valid run", {out_valid, req}, 2'b10);
      chk(out_data == exp_w[i], "R3 word order", out_data, exp_w[i]);
      chk(out_start == (i == 0) && out_end == (i == n - 1), "R6 markers",
          {out_start, out_end}, {i == 0, i == n - 1});
      if (i == n - 1) chk(!in_ready, "R8 closed on last word", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(!out_valid && in_ready, "R8 reopen after packet", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic stray_grant();
    grant = 1'b1;
    repeat (3) @(negedge clk);
    grant = 1'b0;
    chk(!out_valid && !req, "R5 grant with no request", {out_valid, req}, 0);
  endtask

  initial begin
    reset_check();
    run_pkt(0, 0, 0, 1, 0, 0, 0);   // R2 4 words
    run_pkt(1, 1, 1, 2, 0, 0, 0);   // R2 8 words, R9 gaps
    run_pkt(2, 2, 0, 5, 0, 0, 1);   // R2 16 words, R8 flood
    run_pkt(0, 3, 2, 1, 0, 0, 0);   // R2 32 words, R9 gaps
    run_pkt(1, 5, 0, 1, 0, 0, 0);   // R2 code bit 2 ignored -> 8
    run_pkt(2, 4, 0, 0, 1, 0, 0);   // R5 early grant, code 4 -> 4
    stray_grant();                  // R5
    run_pkt(0, 1, 1, 3, 0, 1, 1);   // R7 id/code change mid-gather
    run_pkt(2, 7, 0, 40, 1, 1, 1);  // R4 long wait, code 7 -> 32
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule